// File: doc/BRIEF.md
# Pixel Lane Demultiplexer

This block sits between a pixel decoder and a flat-panel output port. It takes one pixel per strobe together with its data enable, horizontal sync, vertical sync and three general control bits, and drives an even pixel bus, an odd pixel bus, the matching control outputs and an output data clock. In one-pixel mode every strobed pixel goes straight to the even bus. In two-pixel mode consecutive pixels are paired: the first goes to the even bus and the second to the odd bus, so the output clock runs at half the pixel rate.

The core clock `clk` runs at twice the fastest output clock rate, and a pixel is presented with `in_stb` on every other cycle or less often. In one-pixel mode the output clock period is two core cycles. In two-pixel mode it is four core cycles. In that mode the even bus can be launched one core cycle after the odd bus, which is a quarter of an output clock period, so that fewer output lines switch together. A clock-invert input flips only the output clock. A narrow-colour input clears the two low bits of every 8-bit colour lane, which leaves 6-bit colours MSB-justified.

Top module: `pixel_lane_demux`

## Requirements
- R1: With `sel_two` low, a pixel sampled with `in_stb` appears on `out_even`, with its `out_de`, `out_hs`, `out_vs` and `out_ctl`, right after the clock edge that samples it. With `ck_inv` low, `out_clk` goes high at that edge and low one cycle later.
- R2: With `sel_two` low, `out_odd` is all zeros.
- R3: With `sel_two` high, two consecutive strobed pixels with equal data enable form a pair. The first goes to `out_even` and the second to `out_odd`, both launched at the edge that samples the second. The pair's de, syncs and control bits are those of the first pixel.
- R4: In two-pixel mode, a pixel whose data enable differs from the held first pixel starts a new pair. The held pixel is launched alone with an all-zero odd pixel. Pairing therefore starts on the first active pixel, and an odd-length active run ends with a zero-padded pair.
- R5: In two-pixel mode, `out_clk` stays high for two cycles of each four-cycle period. With `stag_n` high the even bus changes at the same edge as the odd bus. With `stag_n` low it changes one cycle later.
- R6: With `sel_two` low, `stag_n` has no effect, and the even bus updates at the launch edge.
- R7: `ck_inv` high inverts `out_clk` and changes no data or control output.
- R8: With `pix18` high, bits [1:0], [9:8] and [17:16] of both pixel buses are zero (the low two bits of each 8-bit lane).
- R9: A change of `sel_two` drops any held pixel and clears `out_even`, `out_odd` and `out_de` at the next edge. Data and data enable then stay low until a strobed pixel with data enable high follows one with data enable low.
- R10: A reset clears the pixel buses and `out_de`, and leaves `out_clk` equal to `ck_inv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the fastest output clock rate |
| rst_n | input | 1 | Synchronous reset, active low |
| in_stb | input | 1 | Marks a cycle that carries a pixel |
| in_pix | input | 24 | Pixel colour data |
| in_de | input | 1 | Data enable of the pixel |
| in_hs | input | 1 | Horizontal sync of the pixel |
| in_vs | input | 1 | Vertical sync of the pixel |
| in_ctl | input | 3 | General control bits of the pixel |
| sel_two | input | 1 | High: two pixels per output clock |
| stag_n | input | 1 | High: simultaneous buses; low: even bus delayed (two-pixel mode only) |
| ck_inv | input | 1 | Inverts the output clock |
| pix18 | input | 1 | Clears the low two bits of each colour lane |
| out_even | output | 24 | Even (first) pixel bus |
| out_odd | output | 24 | Odd (second) pixel bus |
| out_de | output | 1 | Output data enable |
| out_hs | output | 1 | Output horizontal sync |
| out_vs | output | 1 | Output vertical sync |
| out_ctl | output | 3 | Output control bits |
| out_clk | output | 1 | Output data clock |

## Verification
The bench builds the block with its defaults: a 24-bit pixel made of three 8-bit lanes, a 6-bit narrow colour and three control bits. With these values a single narrow pattern reaches the mask on every lane at once. The 3-bit control field lets each pair carry a control code that differs from its second pixel's, so the check can tell which pixel's controls went out. The four-cycle two-pixel period puts the staggered launch exactly one core cycle after the output clock rises, where the bench samples it directly.

// File: rtl/pld_pkg.sv
// Shared definitions for the pixel lane demultiplexer.
package pld_pkg;

    // Output packing mode selected by the pixel-select input.
    typedef enum logic {
        PM_ONE = 1'b0,
        PM_TWO = 1'b1
    } pmode_e;

endpackage

// File: rtl/pld_mode_guard.sv
// Tracks the pixel-select input and the blanking mask.
// A change of the select input raises a restart for one cycle and masks the
// outputs. The mask lifts on a strobed pixel whose data enable is high while
// the previously strobed pixel's was low.
// Assumes sel_two is static during reset (it is loaded then).
module pld_mode_guard
    import pld_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sel_two,
    input  logic   in_stb,
    input  logic   in_de,
    output pmode_e mode,
    output logic   restart,
    output logic   tag_now
);

    logic sel_q;
    logic mute_q;
    logic prev_de;
    logic de_rise;

    assign restart = (sel_two != sel_q);
    assign de_rise = in_stb & in_de & ~prev_de;
    assign mode    = sel_q ? PM_TWO : PM_ONE;

    // Next state of the blanking mask, also tagged onto the incoming pixel.
    always_comb begin
        if (restart) begin
            tag_now = 1'b1;
        end else if (de_rise) begin
            tag_now = 1'b0;
        end else begin
            tag_now = mute_q;
        end
    end

    // Register the select input, the mask and the last strobed data enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= sel_two;
            mute_q  <= 1'b0;
            prev_de <= 1'b0;
        end else begin
            sel_q  <= sel_two;
            mute_q <= tag_now;
            if (in_stb && !restart) begin
                prev_de <= in_de;
            end
        end
    end

endmodule

// File: rtl/pld_pair_unit.sv
// Forms launch events from the strobed pixel stream.
// One-pixel mode: every strobe launches that pixel alone.
// Two-pixel mode: a first pixel is held. A following pixel with the same data
// enable completes the pair. One with a different data enable flushes the held
// pixel alone and becomes the new held pixel.
// Assumes the bundle carries data enable at bit DE_BIT and data in the low PIX_W bits.
module pld_pair_unit
    import pld_pkg::*;
#(
    parameter int unsigned B_W    = 31,
    parameter int unsigned PIX_W  = 24,
    parameter int unsigned DE_BIT = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pmode_e           mode,
    input  logic             restart,
    input  logic             in_stb,
    input  logic [B_W-1:0]   in_b,
    output logic             launch,
    output logic [B_W-1:0]   first_b,
    output logic [PIX_W-1:0] second_d
);

    logic [B_W-1:0] hold_q;
    logic           hold_vld;
    logic           same_de;

    assign same_de = (hold_q[DE_BIT] == in_b[DE_BIT]);

    // Decide whether this cycle launches, and with which pixels.
    always_comb begin
        launch   = 1'b0;
        first_b  = in_b;
        second_d = '0;
        if (!restart && in_stb) begin
            if (mode == PM_ONE) begin
                launch = 1'b1;
            end else if (hold_vld) begin
                launch  = 1'b1;
                first_b = hold_q;
                if (same_de) begin
                    second_d = in_b[PIX_W-1:0];
                end
            end
        end
    end

    // Maintain the held first pixel of the pair under construction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q   <= '0;
            hold_vld <= 1'b0;
        end else if (restart) begin
            hold_vld <= 1'b0;
        end else if (in_stb && mode == PM_TWO) begin
            if (!hold_vld) begin
                hold_q   <= in_b;
                hold_vld <= 1'b1;
            end else if (same_de) begin
                hold_vld <= 1'b0;
            end else begin
                hold_q <= in_b;
            end
        end
    end

endmodule

// File: rtl/pld_launch_stage.sv
// Output registers, narrow-colour masking, even-bus stagger and output clock.
// A launch loads the odd bus and controls at once. The even bus loads at once,
// or one cycle later when staggering in two-pixel mode. The output clock goes
// high at each launch for one cycle (one-pixel) or two cycles (two-pixel).
// Assumes PIX_W is a whole number of LANE_W lanes and NARROW_W < LANE_W.
module pld_launch_stage
    import pld_pkg::*;
#(
    parameter int unsigned PIX_W    = 24,
    parameter int unsigned CTL_W    = 3,
    parameter int unsigned LANE_W   = 8,
    parameter int unsigned NARROW_W = 6,
    parameter int unsigned B_W      = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pmode_e           mode,
    input  logic             restart,
    input  logic             launch,
    input  logic [B_W-1:0]   first_b,
    input  logic [PIX_W-1:0] second_d,
    input  logic             stag_n,
    input  logic             pix18,
    input  logic             ck_inv,
    output logic [PIX_W-1:0] out_even,
    output logic [PIX_W-1:0] out_odd,
    output logic             out_de,
    output logic             out_hs,
    output logic             out_vs,
    output logic [CTL_W-1:0] out_ctl,
    output logic             out_clk
);

    localparam int unsigned LANES   = PIX_W / LANE_W;
    localparam int unsigned DROP_W  = LANE_W - NARROW_W;
    localparam int unsigned VS_BIT  = PIX_W + CTL_W;
    localparam int unsigned HS_BIT  = VS_BIT + 1;
    localparam int unsigned DE_BIT  = VS_BIT + 2;
    localparam int unsigned TAG_BIT = VS_BIT + 3;

    logic [PIX_W-1:0] keep_mask;
    logic [PIX_W-1:0] eff_mask;
    logic [PIX_W-1:0] even_d;
    logic [PIX_W-1:0] odd_d;
    logic [PIX_W-1:0] pend_q;
    logic             pend_vld;
    logic             muted;
    logic             stag_use;
    logic             ck_raw;
    logic             ck_hold;

    // Per-lane mask keeping the upper NARROW_W bits of each colour lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign keep_mask[g*LANE_W +: LANE_W] = {{NARROW_W{1'b1}}, {DROP_W{1'b0}}};
    end

    assign eff_mask = pix18 ? keep_mask : '1;
    assign muted    = first_b[TAG_BIT];
    assign even_d   = muted ? '0 : (first_b[PIX_W-1:0] & eff_mask);
    assign odd_d    = muted ? '0 : (second_d & eff_mask);
    assign stag_use = (mode == PM_TWO) && !stag_n;
    assign out_clk  = ck_raw ^ ck_inv;

    // Load the pixel buses and controls on launch; apply the delayed even bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_even <= '0;
            out_odd  <= '0;
            out_de   <= 1'b0;
            out_hs   <= 1'b0;
            out_vs   <= 1'b0;
            out_ctl  <= '0;
            pend_q   <= '0;
            pend_vld <= 1'b0;
        end else if (restart) begin
            out_even <= '0;
            out_odd  <= '0;
            out_de   <= 1'b0;
            pend_vld <= 1'b0;
        end else begin
            pend_vld <= 1'b0;
            if (pend_vld) begin
                out_even <= pend_q;
            end
            if (launch) begin
                out_odd <= odd_d;
                out_de  <= first_b[DE_BIT] & ~muted;
                out_hs  <= first_b[HS_BIT];
                out_vs  <= first_b[VS_BIT];
                out_ctl <= first_b[PIX_W +: CTL_W];
                if (stag_use) begin
                    pend_q   <= even_d;
                    pend_vld <= 1'b1;
                end else begin
                    out_even <= even_d;
                end
            end
        end
    end

    // Output clock: high from each launch for one or two cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_raw  <= 1'b0;
            ck_hold <= 1'b0;
        end else if (launch) begin
            ck_raw  <= 1'b1;
            ck_hold <= (mode == PM_TWO);
        end else if (ck_hold) begin
            ck_hold <= 1'b0;
        end else begin
            ck_raw <= 1'b0;
        end
    end

endmodule

// File: rtl/pixel_lane_demux.sv
// Top of the pixel lane demultiplexer.
// Packs strobed pixels onto an even and an odd bus in one- or two-pixel mode,
// with optional even-bus stagger, output clock inversion and narrow colours.
// Assumes in_stb is never high on two adjacent cycles and clk runs at twice
// the fastest output clock rate.
module pixel_lane_demux #(
    parameter int unsigned PIX_W    = 24,
    parameter int unsigned CTL_W    = 3,
    parameter int unsigned LANE_W   = 8,
    parameter int unsigned NARROW_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_stb,
    input  logic [PIX_W-1:0] in_pix,
    input  logic             in_de,
    input  logic             in_hs,
    input  logic             in_vs,
    input  logic [CTL_W-1:0] in_ctl,
    input  logic             sel_two,
    input  logic             stag_n,
    input  logic             ck_inv,
    input  logic             pix18,
    output logic [PIX_W-1:0] out_even,
    output logic [PIX_W-1:0] out_odd,
    output logic             out_de,
    output logic             out_hs,
    output logic             out_vs,
    output logic [CTL_W-1:0] out_ctl,
    output logic             out_clk
);

    import pld_pkg::*;

    localparam int unsigned B_W    = PIX_W + CTL_W + 4;
    localparam int unsigned DE_BIT = PIX_W + CTL_W + 2;

    pmode_e           mode;
    logic             restart;
    logic             tag_now;
    logic [B_W-1:0]   in_b;
    logic             launch;
    logic [B_W-1:0]   first_b;
    logic [PIX_W-1:0] second_d;

    // Bundle layout: {mask tag, de, hs, vs, ctl, data}.
    assign in_b = {tag_now, in_de, in_hs, in_vs, in_ctl, in_pix};

    pld_mode_guard u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_two (sel_two),
        .in_stb  (in_stb),
        .in_de   (in_de),
        .mode    (mode),
        .restart (restart),
        .tag_now (tag_now)
    );

    pld_pair_unit #(
        .B_W    (B_W),
        .PIX_W  (PIX_W),
        .DE_BIT (DE_BIT)
    ) u_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .restart  (restart),
        .in_stb   (in_stb),
        .in_b     (in_b),
        .launch   (launch),
        .first_b  (first_b),
        .second_d (second_d)
    );

    pld_launch_stage #(
        .PIX_W    (PIX_W),
        .CTL_W    (CTL_W),
        .LANE_W   (LANE_W),
        .NARROW_W (NARROW_W),
        .B_W      (B_W)
    ) u_launch (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .restart  (restart),
        .launch   (launch),
        .first_b  (first_b),
        .second_d (second_d),
        .stag_n   (stag_n),
        .pix18    (pix18),
        .ck_inv   (ck_inv),
        .out_even (out_even),
        .out_odd  (out_odd),
        .out_de   (out_de),
        .out_hs   (out_hs),
        .out_vs   (out_vs),
        .out_ctl  (out_ctl),
        .out_clk  (out_clk)
    );

endmodule

// File: rtl/pld_checker.sv
// Property checker for pixel_lane_demux, attached by bind.
// Observes only top-level ports.
module pld_checker #(
    parameter int unsigned PIX_W    = 24,
    parameter int unsigned LANE_W   = 8,
    parameter int unsigned NARROW_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel_two,
    input logic             stag_n,
    input logic             ck_inv,
    input logic             pix18,
    input logic [PIX_W-1:0] out_even,
    input logic [PIX_W-1:0] out_odd,
    input logic             out_de,
    input logic             out_clk
);

    // Bits dropped in narrow colour mode.
    function automatic logic [PIX_W-1:0] low_bits();
        logic [PIX_W-1:0] m;
        m = '0;
        for (int i = 0; i < PIX_W; i++) begin
            if ((i % LANE_W) < (LANE_W - NARROW_W)) begin
                m[i] = 1'b1;
            end
        end
        return m;
    endfunction

    localparam logic [PIX_W-1:0] LOW_M = low_bits();

    AST_ODD_ZERO_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!sel_two) |-> (out_odd == '0)); // R2

    AST_ONE_EVEN_AT_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!sel_two) && $past(!sel_two, 2) && !$stable(out_even)
        |-> (out_clk != ck_inv)); // R6

    AST_STAGGER_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel_two) && $past(sel_two, 2) && $past(!stag_n) && $past(!stag_n, 2)
        && !$stable(out_even) |-> $past(out_clk != ck_inv)); // R5

    AST_SEL_CHANGE_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel_two) != $past(sel_two, 2))
        |-> (!out_de && out_even == '0 && out_odd == '0)); // R9

    AST_NARROW_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_odd) && $past(pix18) |-> ((out_odd & LOW_M) == '0)); // R8

    AST_NARROW_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_even) && $past(pix18) && $past(pix18, 2)
        |-> ((out_even & LOW_M) == '0)); // R8

endmodule

bind pixel_lane_demux pld_checker #(
    .PIX_W    (PIX_W),
    .LANE_W   (LANE_W),
    .NARROW_W (NARROW_W)
) u_pld_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_two  (sel_two),
    .stag_n   (stag_n),
    .ck_inv   (ck_inv),
    .pix18    (pix18),
    .out_even (out_even),
    .out_odd  (out_odd),
    .out_de   (out_de),
    .out_clk  (out_clk)
);

// File: tb/pixel_lane_demux_bench.sv
module pixel_lane_demux_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_stb = 1'b0;
    logic [23:0] in_pix = '0;
    logic        in_de = 1'b0;
    logic        in_hs = 1'b0;
    logic        in_vs = 1'b0;
    logic [2:0]  in_ctl = '0;
    logic        sel_two = 1'b0;
    logic        stag_n = 1'b1;
    logic        ck_inv = 1'b0;
    logic        pix18 = 1'b0;
    logic [23:0] out_even;
    logic [23:0] out_odd;
    logic        out_de;
    logic        out_hs;
    logic        out_vs;
    logic [2:0]  out_ctl;
    logic        out_clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pixel_lane_demux u_pixel_lane_demux (
        .clk(clk), .rst_n(rst_n), .in_stb(in_stb), .in_pix(in_pix),
        .in_de(in_de), .in_hs(in_hs), .in_vs(in_vs), .in_ctl(in_ctl),
        .sel_two(sel_two), .stag_n(stag_n), .ck_inv(ck_inv), .pix18(pix18),
        .out_even(out_even), .out_odd(out_odd), .out_de(out_de),
        .out_hs(out_hs), .out_vs(out_vs), .out_ctl(out_ctl), .out_clk(out_clk)
    );

    typedef struct packed {
        logic [23:0] data;
        logic        de;
        logic        hs;
        logic        vs;
        logic [2:0]  ctl;
        logic        stg_n;
        logic        p18;
        logic        inv;
    } row_t;

    // One-pixel mode vectors: pixel, controls and static pin settings.
    localparam row_t ROWS [6] = '{
        '{24'h123456, 1'b1, 1'b0, 1'b0, 3'd1, 1'b1, 1'b0, 1'b0},
        '{24'hABCDEF, 1'b1, 1'b1, 1'b0, 3'd2, 1'b0, 1'b0, 1'b0},
        '{24'h3F3F3F, 1'b1, 1'b0, 1'b1, 3'd4, 1'b1, 1'b1, 1'b0},
        '{24'hFFFFFF, 1'b0, 1'b1, 1'b1, 3'd7, 1'b0, 1'b1, 1'b1},
        '{24'h000001, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b1},
        '{24'h800080, 1'b1, 1'b0, 1'b1, 3'd3, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [23:0] d, input logic de, input logic hs,
                        input logic vs, input logic [2:0] c);
        @(negedge clk);
        in_pix = d; in_de = de; in_hs = hs; in_vs = vs; in_ctl = c;
        in_stb = 1'b1;
        @(negedge clk);
        in_stb = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [23:0] exp_d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check("R10 even", out_even, 0);
        check("R10 odd", out_odd, 0);
        check("R10 de", out_de, 0);
        check("R10 clk", out_clk, 0);

        // R1 R2 R6 R7 R8: one-pixel table
        for (int i = 0; i < 6; i++) begin
            stag_n = ROWS[i].stg_n;
            pix18  = ROWS[i].p18;
            ck_inv = ROWS[i].inv;
            send(ROWS[i].data, ROWS[i].de, ROWS[i].hs, ROWS[i].vs, ROWS[i].ctl);
            exp_d = ROWS[i].p18 ? (ROWS[i].data & 24'hFCFCFC) : ROWS[i].data;
            check(ROWS[i].p18 ? "R8 even narrow" : (ROWS[i].stg_n ? "R1 even" : "R6 even"),
                  out_even, exp_d);
            check("R2 odd zero", out_odd, 0);
            check("R1 controls", {out_de, out_hs, out_vs, out_ctl},
                  {ROWS[i].de, ROWS[i].hs, ROWS[i].vs, ROWS[i].ctl});
            check("R7 clk high phase", out_clk, 1'b1 ^ ROWS[i].inv);
            @(negedge clk);
            check("R7 clk low phase", out_clk, 1'b0 ^ ROWS[i].inv);
        end
        stag_n = 1'b1; pix18 = 1'b0; ck_inv = 1'b0;

        // R9: switch to two-pixel mode
        @(negedge clk);
        sel_two = 1'b1;
        @(negedge clk);
        check("R9 even cleared", out_even, 0);
        check("R9 de cleared", out_de, 0);
        send(24'h111111, 1'b0, 1'b0, 1'b0, 3'd0);
        send(24'h222222, 1'b0, 1'b0, 1'b0, 3'd0);
        check("R9 muted even", out_even, 0);
        check("R9 muted odd", out_odd, 0);

        // R4 and R3: flush on data enable rise, then pairs
        send(24'h333333, 1'b0, 1'b0, 1'b0, 3'd0);
        send(24'hA1A1A1, 1'b1, 1'b1, 1'b0, 3'd5);
        check("R4 flush de", out_de, 0);
        send(24'hA2A2A2, 1'b1, 1'b0, 1'b1, 3'd2);
        check("R3 even first", out_even, 24'hA1A1A1);
        check("R3 odd second", out_odd, 24'hA2A2A2);
        check("R3 controls of first", {out_de, out_hs, out_vs, out_ctl}, {1'b1, 1'b1, 1'b0, 3'd5});
        check("R5 clk high", out_clk, 1);
        send(24'hA3A3A3, 1'b1, 1'b0, 1'b0, 3'd1);
        send(24'hB3B3B3, 1'b0, 1'b1, 1'b0, 3'd6);
        check("R4 padded even", out_even, 24'hA3A3A3);
        check("R4 padded odd", out_odd, 0);
        check("R4 padded de", out_de, 1);
        send(24'hB4B4B4, 1'b0, 1'b0, 1'b0, 3'd0);
        check("R3 blank pair even", out_even, 24'hB3B3B3);
        check("R3 blank pair odd", out_odd, 24'hB4B4B4);
        check("R3 blank pair ctl", {out_de, out_hs, out_ctl}, {1'b0, 1'b1, 3'd6});

        // R5: staggered even bus
        stag_n = 1'b0;
        send(24'hC1C1C1, 1'b0, 1'b0, 1'b0, 3'd0);
        send(24'hC2C2C2, 1'b0, 1'b0, 1'b0, 3'd0);
        check("R5 odd at launch", out_odd, 24'hC2C2C2);
        check("R5 even not yet", out_even, 24'hB3B3B3);
        check("R5 clk high first", out_clk, 1);
        @(negedge clk);
        check("R5 even one cycle late", out_even, 24'hC1C1C1);
        check("R5 clk high second", out_clk, 1);
        @(negedge clk);
        check("R5 clk low", out_clk, 0);

        // R9 and R2: back to one-pixel mode
        sel_two = 1'b0;
        @(negedge clk);
        check("R2 odd after switch", out_odd, 0);
        check("R9 de after switch", out_de, 0);
        send(24'h5A5A5A, 1'b1, 1'b0, 1'b0, 3'd0);
        check("R9 shown after de rise", out_even, 24'h5A5A5A);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule